// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one burst request into the run of column addresses a memory data path steps through. A request gives a starting column, a burst-length code and an ordering bit. The code and the bit normally come from the memory's mode setting. A single-cycle `start` pulse launches the burst. From the next cycle on, the block presents one column address per clock with a valid flag. A last flag marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned block of columns. The order inside that block is either counting upward with wrap-around or the start column XORed with the beat index. A full-page burst walks through the whole 256-column row and wraps from the top column to column 0. It only stops when `terminate` is asserted. Settings that are not allowed produce a one-cycle error flag and no addresses. These are the unused length codes, full page combined with XOR order, and full page from an odd column.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `col_valid`, `col_last` and `cfg_err` are 0.
- R2: A `start` sampled while idle with `len_code` 3'b001, 3'b010 or 3'b011 produces 2, 4 or 8 beats. Beat 0 appears in the cycle after the start edge, one beat per cycle follows, and `col_last` is 1 on the final beat only.
- R3: With `interleave`=0 and a fixed length BL, beat k carries the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits are unchanged.
- R4: With `interleave`=1 and a fixed length BL, beat k carries the start column XOR k.
- R5: `len_code` 3'b111 with `interleave`=0 and an even start gives a full-page burst. Beat k is (start + k) mod 256, `col_last` stays 0, and the beats continue until terminated.
- R6: `terminate` high at a clock edge while `col_valid` is 1 makes the current beat the final one, so `col_valid` is 0 in the next cycle. This applies to both fixed and full-page bursts.
- R7: A start with `len_code` 3'b000, 3'b100, 3'b101 or 3'b110, or with 3'b111 and `interleave`=1, raises `cfg_err` for one cycle (the cycle after the start edge) and produces no beats.
- R8: A full-page start from an odd column raises `cfg_err` for one cycle and produces no beats.
- R9: A `start` sampled while a burst is running is ignored. The running burst keeps its addresses and length, and no further beats follow it.
- R10: `cfg_err` and `col_valid` are never 1 together, and `col_last` is 1 only when `col_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a burst when the block is idle |
| start_col | input | 8 | First column of the burst |
| len_code | input | 3 | Burst-length code |
| interleave | input | 1 | 0 = upward wrapping order, 1 = XOR order |
| terminate | input | 1 | Ends the running burst after the current beat |
| col_addr | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A beat is presented this cycle |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cfg_err | output | 1 | Rejected request, one-cycle pulse |

## Verification
The hardest case to reach is the full-page wrap. The column counter has to run past 255 back to 0 and keep going until a terminate arrives at a chosen beat. The stimulus starts a full page near the top of the row and holds it for 260 beats. It then raises `terminate` in the cycle that shows the chosen beat, so the scoreboard sees the wrap and an exact stop. A second case that is hard to reach is a start pulse injected in the middle of a running 8-beat burst, carrying different settings. The queued expectations prove that the pulse changed nothing.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int COL_W_DEF = 8;
    localparam int LEN_W     = 3;

    localparam logic [LEN_W-1:0] LEN_TWO   = 3'b001;
    localparam logic [LEN_W-1:0] LEN_FOUR  = 3'b010;
    localparam logic [LEN_W-1:0] LEN_EIGHT = 3'b011;
    localparam logic [LEN_W-1:0] LEN_PAGE  = 3'b111;

    typedef enum logic {ORD_WRAP = 1'b0, ORD_XOR = 1'b1} order_e;

    typedef struct packed {
        logic   full;
        order_e order;
        logic   bad;
    } mode_t;

    function automatic logic [COL_W_DEF-1:0] mix_col(
        input logic [COL_W_DEF-1:0] base,
        input logic [COL_W_DEF-1:0] cnt,
        input logic [COL_W_DEF-1:0] mask,
        input order_e               ord
    );
        logic [COL_W_DEF-1:0] sum;
        sum = base + cnt;
        if (ord == ORD_XOR) return base ^ (cnt & mask);
        return (base & ~mask) | (sum & mask);
    endfunction

endpackage

// File: rtl/bcg_cfg_decode.sv
module bcg_cfg_decode
    import bcg_pkg::*;
#(
    parameter int COL_W = COL_W_DEF
) (
    input  logic [LEN_W-1:0] len_code,
    input  logic             interleave,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] mask,
    output mode_t            mode
);
    always_comb begin
        mask       = '0;
        mode.full  = 1'b0;
        mode.order = interleave ? ORD_XOR : ORD_WRAP;
        mode.bad   = 1'b0;
        case (len_code)
            LEN_TWO:   mask = COL_W'(1);
            LEN_FOUR:  mask = COL_W'(3);
            LEN_EIGHT: mask = COL_W'(7);
            LEN_PAGE: begin
                mask      = '1;
                mode.full = 1'b1;
            end
            default:   mode.bad = 1'b1;
        endcase
        if (mode.full && (interleave || start_col[0]))
            mode.bad = 1'b1;
    end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
    import bcg_pkg::*;
#(
    parameter int COL_W = COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             terminate,
    input  logic [COL_W-1:0] mask_in,
    input  mode_t            mode_in,
    output logic             active,
    output logic             launch,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] mask_q,
    output logic             last,
    output logic             err
);
    logic full_q;
    logic reject;

    assign launch = start && !active && !mode_in.bad;
    assign reject = start && !active &&  mode_in.bad;
    assign last   = active && !full_q && (cnt == mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            mask_q <= '0;
            full_q <= 1'b0;
            err    <= 1'b0;
        end else begin
            err <= reject;
            if (launch) begin
                active <= 1'b1;
                cnt    <= '0;
                mask_q <= mask_in;
                full_q <= mode_in.full;
            end else if (active) begin
                if (terminate || last) active <= 1'b0;
                else                   cnt    <= cnt + COL_W'(1);
            end
        end
    end
endmodule

// File: rtl/bcg_addr_gen.sv
module bcg_addr_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [COL_W-1:0] start_col,
    input  order_e           order_in,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] base_q;
    order_e           order_q;
    logic [COL_W-1:0] sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            order_q <= ORD_WRAP;
        end else if (launch) begin
            base_q  <= start_col;
            order_q <= order_in;
        end
    end

    assign sum = base_q + cnt;

    always_comb begin
        if (order_q == ORD_XOR) addr = base_q ^ (cnt & mask);
        else                    addr = (base_q & ~mask) | (sum & mask);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W = COL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [LEN_W-1:0] len_code,
    input  logic             interleave,
    input  logic             terminate,
    output logic [COL_W-1:0] col_addr,
    output logic             col_valid,
    output logic             col_last,
    output logic             cfg_err
);
    logic [COL_W-1:0] dec_mask;
    mode_t            dec_mode;
    logic             active;
    logic             launch;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] mask_q;
    logic             last;
    logic             err;

    bcg_cfg_decode #(.COL_W(COL_W)) dec_i (
        .len_code  (len_code),
        .interleave(interleave),
        .start_col (start_col),
        .mask      (dec_mask),
        .mode      (dec_mode)
    );

    bcg_beat_ctrl #(.COL_W(COL_W)) ctl_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .terminate(terminate),
        .mask_in  (dec_mask),
        .mode_in  (dec_mode),
        .active   (active),
        .launch   (launch),
        .cnt      (cnt),
        .mask_q   (mask_q),
        .last     (last),
        .err      (err)
    );

    bcg_addr_gen #(.COL_W(COL_W)) agen_i (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .start_col(start_col),
        .order_in (dec_mode.order),
        .cnt      (cnt),
        .mask     (mask_q),
        .addr     (col_addr)
    );

    assign col_valid = active;
    assign col_last  = last;
    assign cfg_err   = err;
endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             terminate,
    input logic [COL_W-1:0] col_addr,
    input logic             col_valid,
    input logic             col_last,
    input logic             cfg_err
);
    p_err_excl_r10: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !col_valid);

    p_last_valid_r10: assert property (@(posedge clk) disable iff (rst)
        col_last |-> col_valid);

    p_last_ends_r2: assert property (@(posedge clk) disable iff (rst)
        col_last |=> !col_valid);

    p_term_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (col_valid && terminate) |=> !col_valid);

    p_keeps_going_r5: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !terminate) |=> col_valid);

    p_addr_moves_r3: assert property (@(posedge clk) disable iff (rst)
        (col_valid && !col_last && !terminate) |=> (col_addr != $past(col_addr)));
endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .terminate(terminate),
    .col_addr (col_addr),
    .col_valid(col_valid),
    .col_last (col_last),
    .cfg_err  (cfg_err)
);

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       interleave = 1'b0;
    logic       terminate = 1'b0;
    logic [7:0] col_addr;
    logic       col_valid;
    logic       col_last;
    logic       cfg_err;

    always #4 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst(rst), .start(start), .start_col(start_col),
        .len_code(len_code), .interleave(interleave), .terminate(terminate),
        .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
        .cfg_err(cfg_err)
    );

    typedef struct {
        bit         err;
        logic [7:0] addr;
        bit         last;
        string      req;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    mon_en = 1'b0;
    bit    done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expectations as beats or error pulses appear
    always @(negedge clk) begin
        if (mon_en && !rst && (col_valid || cfg_err)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9", "unexpected output", {col_valid, cfg_err}, 0);
            end else begin
                item_t it;
                it = q.pop_front();
                if (it.err) begin
                    chk(cfg_err && !col_valid, it.req, "error pulse",
                        {cfg_err, col_valid}, 2);
                end else begin
                    chk(col_valid && !cfg_err, it.req, "valid beat",
                        {col_valid, cfg_err}, 2);
                    chk(col_addr == it.addr, it.req, "column", col_addr, it.addr);
                    chk(col_last == it.last, it.req, "last flag", col_last, it.last);
                end
            end
        end
    end

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 0;
        endcase
    endfunction

    // one request; term_at / inj_at < 0 disables terminate / injected start
    task automatic run(input logic [7:0] col, input logic [2:0] code,
                       input bit il, input int term_at, input int inj_at,
                       input string req);
        int  bl;
        bit  page;
        bit  bad;
        int  nbeats;
        page = (code == 3'b111);
        bl   = len_of(code);
        bad  = (!page && bl == 0) || (page && (il || col[0]));
        if (bad) begin
            item_t e;
            e.err = 1'b1; e.addr = '0; e.last = 1'b0; e.req = req;
            q.push_back(e);
            nbeats = 0;
        end else begin
            nbeats = page ? term_at + 1 :
                     ((term_at >= 0 && term_at + 1 < bl) ? term_at + 1 : bl);
            for (int k = 0; k < nbeats; k++) begin
                item_t b;
                b.err = 1'b0;
                if (page)      b.addr = 8'(col + k);
                else if (il)   b.addr = col ^ 8'(k);
                else           b.addr = (col & ~8'(bl - 1)) | (8'(col + k) & 8'(bl - 1));
                b.last = !page && (k == bl - 1);
                b.req  = req;
                q.push_back(b);
            end
        end
        @(negedge clk);
        start = 1'b1; start_col = col; len_code = code; interleave = il;
        for (int i = 1; i <= nbeats + 3; i++) begin
            @(negedge clk);
            start     = (i == inj_at + 1);
            terminate = (i == term_at + 1);
            if (i == inj_at + 1) begin
                start_col = 8'h90; len_code = 3'b001; interleave = 1'b1;
            end
        end
        start = 1'b0; terminate = 1'b0;
        chk(q.size() == 0, req, "pending expectations", q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!col_valid && !col_last && !cfg_err, "R1", "outputs in reset",
            {col_valid, col_last, cfg_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!col_valid && !col_last && !cfg_err, "R1", "outputs after reset",
            {col_valid, col_last, cfg_err}, 0);
        mon_en = 1'b1;

        run(8'h35, 3'b001, 1'b0, -1, -1, "R2");
        run(8'h4E, 3'b010, 1'b0, -1, -1, "R3");
        run(8'hA5, 3'b011, 1'b0, -1, -1, "R3");
        run(8'h13, 3'b011, 1'b1, -1, -1, "R4");
        run(8'h82, 3'b010, 1'b1, -1, -1, "R4");
        run(8'hFF, 3'b001, 1'b1, -1, -1, "R4");
        run(8'd250, 3'b111, 1'b0, 259, -1, "R5");
        run(8'h00, 3'b111, 1'b0, 3, -1, "R5");
        run(8'h60, 3'b011, 1'b0, 2, -1, "R6");
        run(8'h62, 3'b111, 1'b0, 0, -1, "R6");
        run(8'h10, 3'b000, 1'b0, -1, -1, "R7");
        run(8'h10, 3'b100, 1'b0, -1, -1, "R7");
        run(8'h10, 3'b101, 1'b1, -1, -1, "R7");
        run(8'h10, 3'b110, 1'b0, -1, -1, "R7");
        run(8'h10, 3'b111, 1'b1, -1, -1, "R7");
        run(8'h21, 3'b111, 1'b0, 5, -1, "R8");
        run(8'h1C, 3'b011, 1'b0, -1, 3, "R9");
        run(8'h1C, 3'b010, 1'b1, -1, 3, "R9");
        run(8'hC4, 3'b011, 1'b1, -1, -1, "R10");

        repeat (3) @(negedge clk);
        chk(!col_valid && !cfg_err, "R10", "idle at end", {col_valid, cfg_err}, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule